// File: doc/BRIEF.md
# Flash Command Interface Controller

This block fronts a byte-wide, block-erasable nonvolatile array. A host reaches it over an SRAM-style bus: active-low chip select, output enable and write enable, an address and an 8-bit data path. The controller turns host writes into commands. Reads return array bytes, identifier codes or the status byte, chosen by the current read mode. Byte programming and block erase each take two consecutive host writes: a setup command, then the data byte or the confirm code. An internal write engine then runs the operation against a simple array port. Operation lengths come from parameterized cycle counts.

The address space splits into equal blocks. The top `BW` address bits give the block index, so the default 20-bit address with 4 block bits gives sixteen 64 KB blocks. The command decoder has three states. `CUI_IDLE` accepts single-write commands. `CUI_PROG_SETUP` takes the next write as the byte to program and returns to `CUI_IDLE`. `CUI_ERASE_SETUP` takes the next write as the confirm and returns to `CUI_IDLE`. The write engine has four states. `WSM_IDLE` goes to `WSM_PROG` on a program launch and to `WSM_ERASE` on an erase launch. `WSM_PROG` returns to idle after `WRITE_CYC` cycles, or at once on a voltage fault. `WSM_ERASE` writes 0xFF to each byte of the block, spending `ERASE_PACE` cycles per byte. It goes to `WSM_SUSP` on a suspend request and returns to idle after the last byte or on a voltage fault. `WSM_SUSP` returns to `WSM_ERASE` on resume and keeps its byte position.

The `rp_n` input is both reset and deep powerdown. While it is low, everything is held in reset and all writes are locked out. After it rises, reads stay disabled for `RD_WAKE` cycles and commands are ignored for `WR_WAKE` cycles.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rp_n` is low, `ry_by` is high, `dq_oe` is low, the status error bits are cleared and a running operation stops. After `rp_n` rises, the read mode is array.
- R2: After `rp_n` rises, `dq_oe` stays low until `RD_WAKE` clock edges have passed. It is high from then on while `ce_n` and `oe_n` are both low.
- R3: A host write that completes before `WR_WAKE` clock edges have passed since `rp_n` rose has no effect.
- R4: `dq_oe` is high only when `ce_n` and `oe_n` are both low. In array mode `dq_out` is the array byte at `addr`. A host write is taken on the rising edge of `we_n` while `ce_n` is low.
- R5: Code 0x40 or 0x10, followed by a data write, programs the byte at the second write's address with old AND data. Any program or erase command switches the read mode to status.
- R6: `ry_by` is low for exactly `WRITE_CYC` cycles after a program and for exactly block-size times `ERASE_PACE` cycles after an erase. Otherwise it is high.
- R7: Code 0x20, followed by 0xD0, sets every byte of the block selected by the top `BW` bits of the confirm address to 0xFF. Other blocks are left unchanged.
- R8: Code 0x20 followed by any byte other than 0xD0 sets status bits 5 and 4 and does not change the array.
- R9: Code 0xB0 during an erase suspends it. `ry_by` goes high and status bits 7 and 6 are set, and other blocks read correctly. Code 0xD0 while suspended resumes the erase, which then completes.
- R10: With `vpp_ok` low, program and erase leave the array unchanged. Status bit 3 is set, together with bit 4 for a program or bit 5 for an erase.
- R11: The status byte is bit7 ready, bit6 suspended, bit5 erase error, bit4 program error, bit3 voltage low, with bits 2..0 zero. Code 0x70 selects it for reading. Error bits stay set until code 0x50 clears them.
- R12: Code 0x90 selects identifier reads. `addr[0]` = 0 returns `MFR_ID` and `addr[0]` = 1 returns `DEV_ID`. Code 0xFF returns to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rp_n | input | 1 | Active-low reset and deep powerdown |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable; its rising edge takes a write |
| addr | input | AW | Host address |
| dq_in | input | 8 | Host write data or command |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Drive enable for the data pins; low means high impedance |
| vpp_ok | input | 1 | Programming voltage valid |
| ry_by | output | 1 | Ready (high) or busy (low); always driven |
| mem_addr | output | AW | Array address |
| mem_rdata | input | 8 | Array read data, combinational from `mem_addr` |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench uses a small configuration with a 256-byte array and 16-byte blocks. Every address is programmed with a data pattern that clears some bits and keeps others. The setup code alternates between 0x40 and 0x10, and the busy length is measured on each write, so an OR merge, a full overwrite or a missing setup code shows up as wrong array bytes. Erase is tried run to completion, suspended and resumed, interrupted by powerdown, started with the voltage low, and broken by a wrong confirm byte. These cases separate an erase that resumes from its byte position from one that restarts or skips bytes, and separate sticky errors from errors that clear themselves. Writes and reads sent around the wake windows check the two delays separately.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rmode_t;
    typedef enum logic [1:0] {CUI_IDLE, CUI_PROG_SETUP, CUI_ERASE_SETUP} cui_t;
    typedef enum logic [1:0] {WSM_IDLE, WSM_PROG, WSM_ERASE, WSM_SUSP} wsm_t;

    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_READ_ID      = 8'h90;
    localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] CMD_PROG_A       = 8'h40;
    localparam logic [7:0] CMD_PROG_B       = 8'h10;
    localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND      = 8'hB0;
endpackage

// File: rtl/fcc_host_port.sv
module fcc_host_port #(
    parameter int RD_WAKE = 20,
    parameter int WR_WAKE = 50000
) (
    input  logic clk,
    input  logic rp_n,
    input  logic ce_n,
    input  logic we_n,
    output logic wr_stb,
    output logic rd_ok
);
    localparam int CW = $clog2(WR_WAKE + 1);

    logic [CW-1:0] wake_cnt;
    logic          we_q;
    logic          wr_ok;

    always_ff @(posedge clk or negedge rp_n) begin
        if (!rp_n) begin
            wake_cnt <= '0;
            we_q     <= 1'b1;
        end else begin
            we_q <= we_n;
            if (wake_cnt != CW'(WR_WAKE))
                wake_cnt <= wake_cnt + 1'b1;
        end
    end

    always_comb begin
        rd_ok  = (wake_cnt >= CW'(RD_WAKE));
        wr_ok  = (wake_cnt == CW'(WR_WAKE));
        wr_stb = wr_ok && !ce_n && we_n && !we_q;
    end

    // R2 / R3: the read window always opens no later than the write window
    a_r2_wake_order: assert property (@(posedge clk) disable iff (!rp_n)
        wr_ok |-> rd_ok);
endmodule

// File: rtl/fcc_cmd.sv
module fcc_cmd
    import fcc_pkg::*;
(
    input  logic       clk,
    input  logic       rp_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       wsm_busy,
    input  logic       wsm_erasing,
    input  logic       wsm_susp,
    input  logic       prog_fail,
    input  logic       erase_fail,
    output rmode_t     rmode,
    output logic       start_prog,
    output logic       start_erase,
    output logic       susp_req,
    output logic       resume_req,
    output logic [7:0] status
);
    cui_t   cui_q, cui_d;
    rmode_t mode_q, mode_d;
    logic   e_erase_q, e_prog_q, e_vpp_q;
    logic   clr, seq_err;

    always_ff @(posedge clk or negedge rp_n) begin
        if (!rp_n) begin
            cui_q     <= CUI_IDLE;
            mode_q    <= RM_ARRAY;
            e_erase_q <= 1'b0;
            e_prog_q  <= 1'b0;
            e_vpp_q   <= 1'b0;
        end else begin
            cui_q     <= cui_d;
            mode_q    <= mode_d;
            e_erase_q <= (e_erase_q && !clr) || seq_err || erase_fail;
            e_prog_q  <= (e_prog_q && !clr) || seq_err || prog_fail;
            e_vpp_q   <= (e_vpp_q && !clr) || prog_fail || erase_fail;
        end
    end

    always_comb begin
        cui_d       = cui_q;
        mode_d      = mode_q;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        susp_req    = 1'b0;
        resume_req  = 1'b0;
        clr         = 1'b0;
        seq_err     = 1'b0;
        if (wr_stb) begin
            unique case (cui_q)
                CUI_IDLE: begin
                    if (wsm_busy) begin
                        if (wr_data == CMD_SUSPEND && wsm_erasing)
                            susp_req = 1'b1;
                    end else begin
                        case (wr_data)
                            CMD_READ_ARRAY:   mode_d = RM_ARRAY;
                            CMD_READ_ID:      mode_d = RM_IDENT;
                            CMD_READ_STATUS:  mode_d = RM_STATUS;
                            CMD_CLEAR_STATUS: clr = 1'b1;
                            CMD_PROG_A, CMD_PROG_B: begin
                                if (!wsm_susp) begin
                                    cui_d  = CUI_PROG_SETUP;
                                    mode_d = RM_STATUS;
                                end
                            end
                            CMD_ERASE_SETUP: begin
                                if (!wsm_susp) begin
                                    cui_d  = CUI_ERASE_SETUP;
                                    mode_d = RM_STATUS;
                                end
                            end
                            CMD_CONFIRM: begin
                                if (wsm_susp) begin
                                    resume_req = 1'b1;
                                    mode_d     = RM_STATUS;
                                end
                            end
                            CMD_SUSPEND: mode_d = RM_STATUS;
                            default: ;
                        endcase
                    end
                end
                CUI_PROG_SETUP: begin
                    start_prog = 1'b1;
                    cui_d      = CUI_IDLE;
                end
                CUI_ERASE_SETUP: begin
                    cui_d = CUI_IDLE;
                    if (wr_data == CMD_CONFIRM)
                        start_erase = 1'b1;
                    else
                        seq_err = 1'b1;
                end
                default: cui_d = CUI_IDLE;
            endcase
        end
    end

    always_comb begin
        rmode  = mode_q;
        status = {!wsm_busy, wsm_susp, e_erase_q, e_prog_q, e_vpp_q, 3'b000};
    end

    // R11: error bits are sticky until a clear command
    a_r11_sticky_erase: assert property (@(posedge clk) disable iff (!rp_n)
        (e_erase_q && !clr) |=> e_erase_q);
    // R8: a broken erase sequence flags both error bits
    a_r8_seq_flags: assert property (@(posedge clk) disable iff (!rp_n)
        (wr_stb && cui_q == CUI_ERASE_SETUP && wr_data != CMD_CONFIRM)
        |=> (e_erase_q && e_prog_q));
endmodule

// File: rtl/fcc_wsm.sv
module fcc_wsm
    import fcc_pkg::*;
#(
    parameter int AW         = 20,
    parameter int BW         = 4,
    parameter int WRITE_CYC  = 8,
    parameter int ERASE_PACE = 4
) (
    input  logic          clk,
    input  logic          rp_n,
    input  logic          vpp_ok,
    input  logic          start_prog,
    input  logic          start_erase,
    input  logic          susp_req,
    input  logic          resume_req,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_data,
    input  logic [7:0]    arr_rdata,
    output logic          busy,
    output logic          erasing,
    output logic          suspended,
    output logic          prog_fail,
    output logic          erase_fail,
    output logic          arr_we,
    output logic [AW-1:0] arr_waddr,
    output logic [7:0]    arr_wdata
);
    localparam int OFFW  = AW - BW;
    localparam int MAXC  = (WRITE_CYC > ERASE_PACE) ? WRITE_CYC : ERASE_PACE;
    localparam int CNTW  = $clog2(MAXC + 1);

    wsm_t            st;
    logic [CNTW-1:0] cnt;
    logic [AW-1:0]   p_addr;
    logic [7:0]      p_data;
    logic [BW-1:0]   blk;
    logic [OFFW-1:0] off;
    logic            step, last;

    always_comb begin
        step = (cnt == '0);
        last = &off;
    end

    always_ff @(posedge clk or negedge rp_n) begin
        if (!rp_n) begin
            st     <= WSM_IDLE;
            cnt    <= '0;
            p_addr <= '0;
            p_data <= '0;
            blk    <= '0;
            off    <= '0;
        end else begin
            unique case (st)
                WSM_IDLE: begin
                    if (start_prog) begin
                        st     <= WSM_PROG;
                        cnt    <= CNTW'(WRITE_CYC - 1);
                        p_addr <= cmd_addr;
                        p_data <= cmd_data;
                    end else if (start_erase) begin
                        st  <= WSM_ERASE;
                        cnt <= CNTW'(ERASE_PACE - 1);
                        blk <= cmd_addr[AW-1 -: BW];
                        off <= '0;
                    end
                end
                WSM_PROG: begin
                    if (!vpp_ok || step) st <= WSM_IDLE;
                    else cnt <= cnt - 1'b1;
                end
                WSM_ERASE: begin
                    if (!vpp_ok) begin
                        st <= WSM_IDLE;
                    end else begin
                        if (step) begin
                            cnt <= CNTW'(ERASE_PACE - 1);
                            if (last) st <= WSM_IDLE;
                            else off <= off + 1'b1;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                        if (susp_req && !(step && last)) st <= WSM_SUSP;
                    end
                end
                WSM_SUSP: begin
                    if (resume_req) begin
                        st  <= WSM_ERASE;
                        cnt <= CNTW'(ERASE_PACE - 1);
                    end
                end
                default: st <= WSM_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (st == WSM_PROG) || (st == WSM_ERASE);
        erasing    = (st == WSM_ERASE);
        suspended  = (st == WSM_SUSP);
        prog_fail  = (st == WSM_PROG) && !vpp_ok;
        erase_fail = (st == WSM_ERASE) && !vpp_ok;
        arr_we     = busy && vpp_ok && step;
        arr_waddr  = (st == WSM_PROG) ? p_addr : {blk, off};
        arr_wdata  = (st == WSM_PROG) ? (arr_rdata & p_data) : 8'hFF;
    end

    // R10: a missing programming voltage ends the operation at once
    a_r10_abort: assert property (@(posedge clk) disable iff (!rp_n)
        (busy && !vpp_ok) |=> (st == WSM_IDLE));
    // R5: a program writes the array once and then finishes
    a_r5_single_write: assert property (@(posedge clk) disable iff (!rp_n)
        (st == WSM_PROG && arr_we) |=> (st == WSM_IDLE));
    // R9: resuming keeps the byte position of the suspended erase
    a_r9_resume_offset: assert property (@(posedge clk) disable iff (!rp_n)
        (st == WSM_ERASE && $past(st) == WSM_SUSP) |-> (off == $past(off)));
    // R7: erase stores only the all-ones byte
    a_r7_erase_ones: assert property (@(posedge clk) disable iff (!rp_n)
        (arr_we && st == WSM_ERASE) |-> (arr_wdata == 8'hFF));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int         AW         = 20,
    parameter int         BW         = 4,
    parameter int         WRITE_CYC  = 8,
    parameter int         ERASE_PACE = 4,
    parameter int         RD_WAKE    = 20,
    parameter int         WR_WAKE    = 50000,
    parameter logic [7:0] MFR_ID     = 8'h5A,
    parameter logic [7:0] DEV_ID     = 8'hC3
) (
    input  logic          clk,
    input  logic          rp_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    dq_in,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    input  logic          vpp_ok,
    output logic          ry_by,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          mem_we,
    output logic [7:0]    mem_wdata
);
    logic          wr_stb, rd_ok;
    rmode_t        rmode;
    logic          start_prog, start_erase, susp_req, resume_req;
    logic [7:0]    status;
    logic          busy, erasing, suspended, prog_fail, erase_fail;
    logic [AW-1:0] wsm_addr;

    fcc_host_port #(.RD_WAKE(RD_WAKE), .WR_WAKE(WR_WAKE)) u_port (
        .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n),
        .wr_stb(wr_stb), .rd_ok(rd_ok)
    );

    fcc_cmd u_cmd (
        .clk(clk), .rp_n(rp_n), .wr_stb(wr_stb), .wr_data(dq_in),
        .wsm_busy(busy), .wsm_erasing(erasing), .wsm_susp(suspended),
        .prog_fail(prog_fail), .erase_fail(erase_fail),
        .rmode(rmode), .start_prog(start_prog), .start_erase(start_erase),
        .susp_req(susp_req), .resume_req(resume_req), .status(status)
    );

    fcc_wsm #(.AW(AW), .BW(BW), .WRITE_CYC(WRITE_CYC), .ERASE_PACE(ERASE_PACE)) u_wsm (
        .clk(clk), .rp_n(rp_n), .vpp_ok(vpp_ok),
        .start_prog(start_prog), .start_erase(start_erase),
        .susp_req(susp_req), .resume_req(resume_req),
        .cmd_addr(addr), .cmd_data(dq_in), .arr_rdata(mem_rdata),
        .busy(busy), .erasing(erasing), .suspended(suspended),
        .prog_fail(prog_fail), .erase_fail(erase_fail),
        .arr_we(mem_we), .arr_waddr(wsm_addr), .arr_wdata(mem_wdata)
    );

    always_comb begin
        mem_addr = busy ? wsm_addr : addr;
        ry_by    = !busy;
        dq_oe    = rd_ok && !ce_n && !oe_n;
        unique case (rmode)
            RM_ARRAY:  dq_out = mem_rdata;
            RM_IDENT:  dq_out = addr[0] ? DEV_ID : MFR_ID;
            RM_STATUS: dq_out = status;
            default:   dq_out = 8'h00;
        endcase
    end

    // R9: a suspended erase always reports ready on the pin
    a_r9_susp_ready: assert property (@(posedge clk) disable iff (!rp_n)
        status[6] |-> ry_by);
    // R4: the data pins are only driven with both selects low
    a_r4_drive_gate: assert property (@(posedge clk) disable iff (!rp_n)
        dq_oe |-> (!ce_n && !oe_n));
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int BW = 4;
    localparam int WRITE_CYC = 3;
    localparam int ERASE_PACE = 2;
    localparam int RD_WAKE = 4;
    localparam int WR_WAKE = 12;
    localparam logic [7:0] MFR = 8'h5A;
    localparam logic [7:0] DEV = 8'hC3;
    localparam int NB = 1 << AW;
    localparam int BLK = 1 << (AW - BW);

    logic clk = 1'b0;
    logic rp_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vpp_ok = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out, mem_rdata, mem_wdata;
    logic dq_oe, ry_by, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem [0:NB-1];
    logic [7:0] expv [0:NB-1];
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_ctrl #(.AW(AW), .BW(BW), .WRITE_CYC(WRITE_CYC), .ERASE_PACE(ERASE_PACE),
        .RD_WAKE(RD_WAKE), .WR_WAKE(WR_WAKE), .MFR_ID(MFR), .DEV_ID(DEV)) uut (
        .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .vpp_ok(vpp_ok), .ry_by(ry_by),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; dq_in = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic read_byte(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1 d = dq_out;
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (ry_by == 1'b0 && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        int n, k, mism;
        for (int i = 0; i < NB; i++) begin
            mem[i]  = 8'((i * 29 + 7) & 255);
            expv[i] = 8'((i * 29 + 7) & 255);
        end
        // R1: powerdown holds ready high and the pins undriven
        repeat (3) @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        #1 check(ry_by, 1, "R1 ry_by in powerdown");
        check(dq_oe, 0, "R1 dq_oe in powerdown");
        // R2: read wake window
        @(negedge clk); rp_n = 1'b1;
        k = 0;
        while (dq_oe == 1'b0 && k < 100) begin
            @(negedge clk); k++;
        end
        check(k, RD_WAKE, "R2 read wake length");
        ce_n = 1'b1; oe_n = 1'b1;
        // R3: early command ignored, mode stays array
        host_write(8'h00, 8'h90);
        read_byte(8'h00, v);
        check(v, expv[0], "R3 early write ignored");
        repeat (WR_WAKE) @(negedge clk);
        // R12: identifier reads
        host_write(8'h00, 8'h90);
        read_byte(8'h00, v); check(v, MFR, "R12 manufacturer code");
        read_byte(8'h01, v); check(v, DEV, "R12 device code");
        host_write(8'h00, 8'hFF);
        read_byte(8'h01, v); check(v, expv[1], "R12 back to array");
        // R4: output enable gating
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        #1 check(dq_oe, 0, "R4 oe_n high");
        ce_n = 1'b1; oe_n = 1'b0;
        #1 check(dq_oe, 0, "R4 ce_n high");
        ce_n = 1'b0;
        #1 check(dq_oe, 1, "R4 both low");
        ce_n = 1'b1; oe_n = 1'b1;
        // R11: status read after wake
        host_write(8'h00, 8'h70);
        read_byte(8'h00, v); check(v, 8'h80, "R11 idle status");
        // R5 / R6: program sweep over every address
        for (int a = 0; a < NB; a++) begin
            logic [7:0] d;
            d = 8'(((a * 37) ^ 8'hA6) & 255);
            host_write(AW'(a), (a % 2 == 1) ? 8'h10 : 8'h40);
            host_write(AW'(a), d);
            wait_busy(n);
            check(n, WRITE_CYC, "R6 program busy length");
            read_byte(AW'(a), v);
            check(v, 8'h80, "R5 auto status after program");
            expv[a] = expv[a] & d;
        end
        host_write(8'h00, 8'hFF);
        mism = 0;
        for (int a = 0; a < NB; a++) begin
            read_byte(AW'(a), v);
            if (v !== expv[a]) mism++;
        end
        check(mism, 0, "R5 array after program sweep");
        // R7 / R6: full erase of block 5
        host_write(8'h53, 8'h20);
        host_write(8'h53, 8'hD0);
        wait_busy(n);
        check(n, BLK * ERASE_PACE, "R6 erase busy length");
        for (int i = 0; i < BLK; i++) expv[5 * BLK + i] = 8'hFF;
        host_write(8'h00, 8'hFF);
        mism = 0;
        for (int a = 0; a < NB; a++) begin
            read_byte(AW'(a), v);
            if (v !== expv[a]) mism++;
        end
        check(mism, 0, "R7 array after block erase");
        // R8 / R11: broken erase sequence, sticky errors, clear
        host_write(8'h20, 8'h20);
        host_write(8'h20, 8'hFF);
        read_byte(8'h00, v); check(v, 8'hB0, "R8 sequence error status");
        host_write(8'h00, 8'h70);
        read_byte(8'h00, v); check(v, 8'hB0, "R11 errors sticky");
        host_write(8'h00, 8'hFF);
        mism = 0;
        for (int i = 0; i < BLK; i++) begin
            read_byte(AW'(2 * BLK + i), v);
            if (v !== expv[2 * BLK + i]) mism++;
        end
        check(mism, 0, "R8 block unchanged");
        host_write(8'h00, 8'h50);
        host_write(8'h00, 8'h70);
        read_byte(8'h00, v); check(v, 8'h80, "R11 clear status");
        // R9: suspend and resume
        host_write(8'h33, 8'h20);
        host_write(8'h33, 8'hD0);
        repeat (5) @(negedge clk);
        host_write(8'h33, 8'hB0);
        check(ry_by, 1, "R9 ready during suspend");
        read_byte(8'h00, v); check(v, 8'hC0, "R9 suspended status");
        host_write(8'h00, 8'hFF);
        mism = 0;
        for (int i = 0; i < BLK; i++) begin
            read_byte(AW'(4 * BLK + i), v);
            if (v !== expv[4 * BLK + i]) mism++;
        end
        check(mism, 0, "R9 other block readable");
        read_byte(8'h3F, v); check(v, expv[8'h3F], "R9 tail not yet erased");
        host_write(8'h33, 8'hD0);
        wait_busy(n);
        read_byte(8'h00, v); check(v, 8'h80, "R9 status after resume");
        for (int i = 0; i < BLK; i++) expv[3 * BLK + i] = 8'hFF;
        host_write(8'h00, 8'hFF);
        mism = 0;
        for (int i = 0; i < BLK; i++) begin
            read_byte(AW'(3 * BLK + i), v);
            if (v !== 8'hFF) mism++;
        end
        check(mism, 0, "R9 erase completed after resume");
        // R10: programming voltage missing
        vpp_ok = 1'b0;
        host_write(8'h10, 8'h40);
        host_write(8'h10, 8'h00);
        wait_busy(n);
        read_byte(8'h00, v); check(v, 8'h98, "R10 program fault status");
        host_write(8'h00, 8'hFF);
        read_byte(8'h10, v); check(v, expv[8'h10], "R10 byte unchanged");
        host_write(8'h00, 8'h50);
        host_write(8'h63, 8'h20);
        host_write(8'h63, 8'hD0);
        wait_busy(n);
        read_byte(8'h00, v); check(v, 8'hA8, "R10 erase fault status");
        host_write(8'h00, 8'hFF);
        read_byte(8'h60, v); check(v, expv[8'h60], "R10 block start unchanged");
        read_byte(8'h6F, v); check(v, expv[8'h6F], "R10 block end unchanged");
        vpp_ok = 1'b1;
        host_write(8'h00, 8'h50);
        // R1: powerdown during erase with sticky errors set
        host_write(8'h20, 8'h20);
        host_write(8'h20, 8'h00);
        host_write(8'h73, 8'h20);
        host_write(8'h73, 8'hD0);
        repeat (3) @(negedge clk);
        rp_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        #1 check(ry_by, 1, "R1 ready in powerdown during erase");
        check(dq_oe, 0, "R1 pins float in powerdown");
        repeat (3) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; rp_n = 1'b1;
        repeat (WR_WAKE + 2) @(negedge clk);
        read_byte(8'h7F, v); check(v, expv[8'h7F], "R1 array mode after wake");
        host_write(8'h00, 8'h70);
        read_byte(8'h00, v); check(v, 8'h80, "R1 status cleared by powerdown");
        done = 1;
        finish_run();
    end
endmodule